// File: doc/BRIEF.md
# USB Low/Full-Speed Bit-Level Receiver

This block turns the sampled D+ and D- wires of one low- or full-speed USB port into a stream of recovered data bits. Both single-ended line values arrive already synchronised to the local clock. The clock runs at four times the bit rate, so every clock edge is one line sample. A speed-select input decides which differential polarity counts as the idle (J) state.

A small digital PLL realigns the sampling phase on every change of line state. It takes one decision per bit, near the middle of the bit. The decoder reverses the NRZI coding and drops the bits that the transmitter stuffed in. It also finds the sync pattern that opens a packet and the single-ended-zero sequence that closes it. Results leave the block as single-cycle pulses: a data bit with its valid strobe, packet start, clean packet end, a stuffing violation and a line-state error.

Top module: `usb_fs_line_rx`

## Requirements
- R1: While reset is applied and after it is released with an idle line, every output is 0.
- R2: The line state is mapped from {D+, D-} as follows. 00 is SE0 and 11 is SE1. With `low_speed_i`=0, 10 is J and 01 is K. With `low_speed_i`=1, 01 is J and 10 is K. The same packet therefore decodes identically at either speed when the wires are swapped.
- R3: Nominally four samples make one bit. The sampling phase restarts on each line-state change, and one decision is taken per bit. A bit that lasts 3 to 5 samples before a line change still decodes correctly.
- R4: NRZI decoding compares each sampled J/K state with the previous one. A change decodes as data 0 and no change decodes as data 1.
- R5: In sync search, at least 4 consecutive decoded 0 bits followed by a decoded 1 raise `pkt_start_o` for one cycle. The receiver then enters the packet state. Sync bits are never output, and a run of fewer than 4 zeros before the 1 starts nothing.
- R6: The run of consecutive 1 bits starts at one when the packet opens, because the final sync bit is a 1. When the run reaches six, the next bit is taken to be a stuffed 0 and is dropped without a valid strobe.
- R7: If the bit that should be stuffed is a 1, `stuff_err_o` pulses and the receiver returns to sync search without signalling a packet end.
- R8: In the packet state, one or more SE0 bits followed by a J bit raise `pkt_end_o` for one cycle. The receiver then returns to sync search.
- R9: In the packet state, SE0 followed by K, or any SE1 bit, raises `line_err_o` for one cycle and aborts to sync search.
- R10: SE0 or idle J on the line during sync search produces no output pulse.
- R11: Data bits leave the block in the order received, each one with a one-cycle `bit_valid_o`, and only while a packet is open. At most one of the five pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, four times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Synchronised D+ sample |
| dm_i | input | 1 | Synchronised D- sample |
| low_speed_i | input | 1 | 1 selects low-speed J/K polarity |
| bit_o | output | 1 | Recovered data bit |
| bit_valid_o | output | 1 | Strobe qualifying `bit_o` |
| pkt_start_o | output | 1 | Pulse after a complete sync pattern |
| pkt_end_o | output | 1 | Pulse on a valid end of packet |
| stuff_err_o | output | 1 | Pulse on a bit-stuffing violation |
| line_err_o | output | 1 | Pulse on an illegal line state inside a packet |

## Verification
Some rules are checked by assertions on every cycle. These are the line-state mapping, the minimum spacing between PLL decisions, the bound on the ones run and the dropped stuffed bit, the rule that valid bits appear only inside a packet, and the rule that pulse outputs never overlap. The remaining behaviour can only be shown by the bench's scenarios, because it depends on a whole packet's history. That covers the exact recovered bit sequence under phase jitter, recognition or rejection of sync runs, the abort paths, and equal decoding at both speeds.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_SE1 = 2'd3
  } line_state_e;

  typedef enum logic {
    RX_SEARCH = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_e;
endpackage

// File: rtl/usb_rx_line_map.sv
module usb_rx_line_map
  import usb_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dp_i,
  input  logic        dm_i,
  input  logic        low_speed_i,
  output line_state_e ls_o
);
  line_state_e ls_d, ls_q;

  always_comb begin
    unique case ({dp_i, dm_i})
      2'b00:   ls_d = LS_SE0;
      2'b11:   ls_d = LS_SE1;
      2'b10:   ls_d = low_speed_i ? LS_K : LS_J;
      default: ls_d = low_speed_i ? LS_J : LS_K;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ls_q <= LS_J;
    else         ls_q <= ls_d;

  assign ls_o = ls_q;

  assert_se0_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dp_i && !dm_i) |=> ls_o == LS_SE0);
  assert_fs_j_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_i && !dm_i && !low_speed_i) |=> ls_o == LS_J);
  assert_ls_j_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dp_i && dm_i && low_speed_i) |=> ls_o == LS_J);
endmodule

// File: rtl/usb_rx_dpll.sv
module usb_rx_dpll
  import usb_rx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  line_state_e ls_i,
  output logic        stb_o
);
  localparam int PW = (SAMPLES_PER_BIT > 2) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(SAMPLES_PER_BIT - 1);
  localparam logic [PW-1:0] PH_STB  = PW'(SAMPLES_PER_BIT / 2);

  line_state_e   prev_q;
  logic [PW-1:0] phase_q;
  logic          trans;

  assign trans = (ls_i != prev_q);
  assign stb_o = !trans && (phase_q == PH_STB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= LS_J;
      phase_q <= '0;
    end else begin
      prev_q <= ls_i;
      if (trans)                  phase_q <= PW'(1);
      else if (phase_q == PH_LAST) phase_q <= '0;
      else                        phase_q <= phase_q + 1'b1;
    end
  end

  // decisions are at least three samples apart
  assert_stb_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o ##1 !stb_o);
endmodule

// File: rtl/usb_rx_decoder.sv
module usb_rx_decoder
  import usb_rx_pkg::*;
#(
  parameter int SYNC_ZEROS = 4,
  parameter int STUFF_RUN  = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stb_i,
  input  line_state_e ls_i,
  output logic        bit_o,
  output logic        bit_valid_o,
  output logic        pkt_start_o,
  output logic        pkt_end_o,
  output logic        stuff_err_o,
  output logic        line_err_o
);
  localparam int ZW = $clog2(SYNC_ZEROS + 1);
  localparam int CW = $clog2(STUFF_RUN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_ZEROS);
  localparam logic [CW-1:0] OMAX = CW'(STUFF_RUN);

  rx_state_e     state_q;
  line_state_e   prev_q;
  logic [ZW-1:0] zeros_q;
  logic [CW-1:0] ones_q;
  logic          se0_q;
  logic          data_q, valid_q, start_q, end_q, stuff_q, lerr_q;
  logic          is_jk, same;

  assign is_jk = (ls_i == LS_J) || (ls_i == LS_K);
  assign same  = (ls_i == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_SEARCH;
      prev_q  <= LS_J;
      zeros_q <= '0;
      ones_q  <= '0;
      se0_q   <= 1'b0;
      data_q  <= 1'b0;
      valid_q <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      stuff_q <= 1'b0;
      lerr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      stuff_q <= 1'b0;
      lerr_q  <= 1'b0;
      if (stb_i) begin
        unique case (state_q)
          RX_SEARCH: begin
            if (is_jk) begin
              prev_q <= ls_i;
              if (!same) begin
                if (zeros_q != ZMAX) zeros_q <= zeros_q + 1'b1;
              end else begin
                if (zeros_q == ZMAX) begin
                  start_q <= 1'b1;
                  state_q <= RX_ACTIVE;
                  ones_q  <= CW'(1);
                  se0_q   <= 1'b0;
                end
                zeros_q <= '0;
              end
            end else begin
              prev_q  <= LS_J;
              zeros_q <= '0;
            end
          end
          RX_ACTIVE: begin
            if (ls_i == LS_SE0) begin
              se0_q <= 1'b1;
            end else if (ls_i == LS_SE1) begin
              lerr_q  <= 1'b1;
              state_q <= RX_SEARCH;
              se0_q   <= 1'b0;
              prev_q  <= LS_J;
              zeros_q <= '0;
            end else if (se0_q) begin
              se0_q   <= 1'b0;
              state_q <= RX_SEARCH;
              zeros_q <= '0;
              prev_q  <= ls_i;
              if (ls_i == LS_J) end_q  <= 1'b1;
              else              lerr_q <= 1'b1;
            end else begin
              prev_q <= ls_i;
              if (ones_q == OMAX) begin
                ones_q <= '0;
                if (same) begin
                  stuff_q <= 1'b1;
                  state_q <= RX_SEARCH;
                  zeros_q <= '0;
                end
              end else begin
                valid_q <= 1'b1;
                data_q  <= same;
                ones_q  <= same ? ones_q + 1'b1 : '0;
              end
            end
          end
          default: state_q <= RX_SEARCH;
        endcase
      end
    end
  end

  assign bit_o       = data_q;
  assign bit_valid_o = valid_q;
  assign pkt_start_o = start_q;
  assign pkt_end_o   = end_q;
  assign stuff_err_o = stuff_q;
  assign line_err_o  = lerr_q;

  assert_valid_in_packet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> state_q == RX_ACTIVE);
  assert_pulses_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_valid_o, pkt_start_o, pkt_end_o, stuff_err_o, line_err_o}));
  assert_ones_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= OMAX);
  assert_stuffed_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && state_q == RX_ACTIVE && !se0_q && is_jk && ones_q == OMAX) |=> !bit_valid_o);
  assert_start_opens_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> state_q == RX_ACTIVE);
  assert_end_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> state_q == RX_SEARCH);
  assert_stuff_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> state_q == RX_SEARCH);
endmodule

// File: rtl/usb_fs_line_rx.sv
module usb_fs_line_rx
  import usb_rx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int SYNC_ZEROS      = 4,
  parameter int STUFF_RUN       = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  input  logic low_speed_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic pkt_start_o,
  output logic pkt_end_o,
  output logic stuff_err_o,
  output logic line_err_o
);
  line_state_e ls;
  logic        stb;

  usb_rx_line_map u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .low_speed_i (low_speed_i),
    .ls_o        (ls)
  );

  usb_rx_dpll #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) u_dpll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ls_i   (ls),
    .stb_o  (stb)
  );

  usb_rx_decoder #(.SYNC_ZEROS(SYNC_ZEROS), .STUFF_RUN(STUFF_RUN)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (stb),
    .ls_i        (ls),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .pkt_start_o (pkt_start_o),
    .pkt_end_o   (pkt_end_o),
    .stuff_err_o (stuff_err_o),
    .line_err_o  (line_err_o)
  );
endmodule

// File: tb/usb_fs_line_rx_tb_top.sv
module usb_fs_line_rx_tb_top;
  localparam int ST_SE0 = 0, ST_J = 1, ST_K = 2, ST_SE1 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1, dm = 1'b0, low_speed = 1'b0;
  logic bit_o, bit_valid, pkt_start, pkt_end, stuff_err, line_err;

  always #4 clk = ~clk;

  usb_fs_line_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(low_speed),
    .bit_o(bit_o), .bit_valid_o(bit_valid), .pkt_start_o(pkt_start),
    .pkt_end_o(pkt_end), .stuff_err_o(stuff_err), .line_err_o(line_err)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  bit jitter = 1'b0;

  logic pay [0:63];
  int   lst [0:511];
  int   ln;
  int   cur;
  logic rx  [0:255];
  int   rx_n = 0, n_start = 0, n_end = 0, n_stuff = 0, n_lerr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin rx[rx_n] = bit_o; rx_n = rx_n + 1; end
      if (pkt_start) n_start = n_start + 1;
      if (pkt_end)   n_end   = n_end + 1;
      if (stuff_err) n_stuff = n_stuff + 1;
      if (line_err)  n_lerr  = n_lerr + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_n = 0; n_start = 0; n_end = 0; n_stuff = 0; n_lerr = 0;
  endtask

  task automatic set_pins(int st);
    case (st)
      ST_SE0: begin dp = 1'b0; dm = 1'b0; end
      ST_SE1: begin dp = 1'b1; dm = 1'b1; end
      ST_J:   begin dp = !low_speed; dm = low_speed; end
      default: begin dp = low_speed; dm = !low_speed; end
    endcase
  endtask

  task automatic push(int st);
    lst[ln] = st; ln++;
  endtask

  task automatic push_bit(logic b);
    if (!b) cur = (cur == ST_J) ? ST_K : ST_J;
    push(cur);
  endtask

  // eop_kind: 0 clean, 1 SE0 then K, 2 SE1, 3 none
  task automatic build_packet(int plen, bit stuff_on, int eop_kind);
    int ones;
    ln = 0; cur = ST_J;
    push(ST_J); push(ST_J);
    for (int i = 0; i < 7; i++) push_bit(1'b0);
    push_bit(1'b1);
    ones = 1;
    for (int i = 0; i < plen; i++) begin
      push_bit(pay[i]);
      ones = pay[i] ? ones + 1 : 0;
      if (stuff_on && ones == 6) begin push_bit(1'b0); ones = 0; end
    end
    case (eop_kind)
      0: begin push(ST_SE0); push(ST_SE0); end
      1: begin push(ST_SE0); push(ST_SE0); push(ST_K); end
      2: push(ST_SE1);
      default: ;
    endcase
    for (int i = 0; i < 4; i++) push(ST_J);
  endtask

  task automatic drive_line();
    for (int i = 0; i < ln; i++) begin
      int len;
      len = 4;
      if (jitter && i + 1 < ln && lst[i+1] != lst[i]) len = 3 + int'($urandom % 3);
      set_pins(lst[i]);
      repeat (len) @(negedge clk);
    end
    set_pins(ST_J);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_bits(int plen, string req);
    int bad;
    bad = 0;
    check(rx_n == plen, req, "bit count", rx_n, plen);
    for (int i = 0; i < plen && i < rx_n; i++)
      if (rx[i] !== pay[i]) bad++;
    check(bad == 0, req, "mismatched bits", bad, 0);
  endtask

  task automatic run_good(int plen, string req);
    clear_mon();
    build_packet(plen, 1'b1, 0);
    drive_line();
    check_bits(plen, req);
    check(n_start == 1, "R5", "start pulses", n_start, 1);
    check(n_end == 1, "R8", "end pulses", n_end, 1);
    check(n_stuff + n_lerr == 0, "R7", "error pulses", n_stuff + n_lerr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({bit_valid, pkt_start, pkt_end, stuff_err, line_err} == 0, "R1", "outputs in reset",
          {bit_valid, pkt_start, pkt_end, stuff_err, line_err}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(n_start + rx_n + n_end + n_stuff + n_lerr == 0, "R1", "pulses after reset",
          n_start + rx_n + n_end + n_stuff + n_lerr, 0);

    // R4 R11: fixed byte, least significant bit first
    for (int i = 0; i < 8; i++) pay[i] = logic'((8'hA5 >> i) & 1);
    run_good(8, "R4");

    // R6: long run of ones needs stuffing
    for (int i = 0; i < 16; i++) pay[i] = 1'b1;
    run_good(16, "R6");

    // R6: run completing at the last payload bit
    for (int i = 0; i < 5; i++) pay[i] = 1'b1;
    run_good(5, "R6");

    // R2: low-speed polarity
    low_speed = 1'b1;
    set_pins(ST_J);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 24; i++) pay[i] = logic'($urandom % 2);
    run_good(24, "R2");
    low_speed = 1'b0;
    set_pins(ST_J);
    repeat (8) @(negedge clk);

    // R7: seventh one without stuffing
    clear_mon();
    pay[0] = 0; pay[1] = 0;
    for (int i = 2; i < 9; i++) pay[i] = 1'b1;
    pay[9] = 0; pay[10] = 1;
    build_packet(11, 1'b0, 0);
    drive_line();
    check(n_stuff == 1, "R7", "stuff error pulses", n_stuff, 1);
    check(rx_n == 8, "R7", "bits before violation", rx_n, 8);
    check(n_end == 0, "R7", "end pulses after abort", n_end, 0);

    // R9: SE0 followed by K
    clear_mon();
    for (int i = 0; i < 10; i++) pay[i] = logic'($urandom % 2);
    build_packet(10, 1'b1, 1);
    drive_line();
    check(n_lerr == 1, "R9", "line error after SE0-K", n_lerr, 1);
    check(n_end == 0, "R9", "end pulses after SE0-K", n_end, 0);
    check_bits(10, "R9");

    // R9: SE1 inside a packet
    clear_mon();
    build_packet(6, 1'b1, 2);
    drive_line();
    check(n_lerr == 1, "R9", "line error on SE1", n_lerr, 1);
    check(n_end == 0, "R9", "end pulses on SE1", n_end, 0);

    // R10: bus reset while searching
    clear_mon();
    set_pins(ST_SE0);
    repeat (48) @(negedge clk);
    set_pins(ST_J);
    repeat (24) @(negedge clk);
    check(n_start + rx_n + n_end + n_stuff + n_lerr == 0, "R10", "pulses from idle SE0",
          n_start + rx_n + n_end + n_stuff + n_lerr, 0);

    // R5: three zeros then a one is not a sync
    clear_mon();
    ln = 0; cur = ST_J;
    push(ST_J);
    for (int i = 0; i < 3; i++) push_bit(1'b0);
    push_bit(1'b1);
    for (int i = 0; i < 4; i++) push(ST_J);
    drive_line();
    check(n_start == 0, "R5", "start on short sync", n_start, 0);
    check(rx_n == 0, "R5", "bits on short sync", rx_n, 0);

    // R3: random packets with phase jitter and random speed
    jitter = 1'b1;
    for (int p = 0; p < 24; p++) begin
      int plen;
      low_speed = logic'($urandom % 2);
      set_pins(ST_J);
      repeat (8) @(negedge clk);
      plen = 1 + int'($urandom % 48);
      for (int i = 0; i < plen; i++) pay[i] = logic'(($urandom % 4) != 0);
      run_good(plen, "R3");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule